// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block builds a 20-bit physical memory address out of a 16-bit segment base and a 16-bit offset. The segment base is moved up four bit places and then added to the offset. Any carry out of the top bit is dropped, so every address stays inside a 1 MB space.

The block holds four segment base registers: code, data, stack and extra. It also holds an instruction pointer. The access type that is presented picks the base:

- an instruction fetch uses the code base with the instruction pointer as its offset;
- a stack access uses the stack base;
- a data access uses the data base, unless a segment override names another base.

A fetch strobe moves the instruction pointer forward by one byte, and the pointer wraps inside its 64 kB segment.

Software or a sequencer loads the segment registers and the instruction pointer through simple write ports. The address output is combinational from the current register state and the access inputs.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (base × 16 + offset) modulo 2^20, so a sum past 0xFFFFF wraps to the low end of the space.
- R2: When `acc_kind` = 0 (fetch), the base is the code register and the offset is the instruction pointer; the `offset` input has no effect.
- R3: When `acc_kind` = 1 (stack), the base is the stack register and the offset is `offset`.
- R4: When `acc_kind` = 2 or 3 (data) and `ovr_en` = 0, the base is the data register and the offset is `offset`.
- R5: When the access is a data access and `ovr_en` = 1, the base is the register named by `ovr_seg`. The override has no effect on fetch or stack accesses.
- R6: Each clock edge that samples `fetch_stb` = 1 (and `ip_we` = 0) adds exactly one to the instruction pointer.
- R7: Stepping the instruction pointer from 0xFFFF gives 0x0000, and the code register is not changed.
- R8: An edge that samples `ip_we` = 1 loads `ip_wdata` into the instruction pointer. This load wins over `fetch_stb` in the same cycle.
- R9: An edge that samples `seg_we` = 1 loads `seg_wdata` into the register chosen by `seg_sel`, and the other three registers keep their values. Register codes are 0 = code, 1 = data, 2 = stack, 3 = extra; `ovr_seg` uses the same codes.
- R10: While `rst_n` is low, all four segment registers and the instruction pointer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_we | input | 1 | Segment register write enable |
| seg_sel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | Segment write value |
| ip_we | input | 1 | Instruction pointer load enable |
| ip_wdata | input | 16 | Instruction pointer load value |
| fetch_stb | input | 1 | One instruction byte fetched; step the pointer |
| acc_kind | input | 2 | Access type (0 fetch, 1 stack, 2/3 data) |
| ovr_en | input | 1 | Apply the segment override to a data access |
| ovr_seg | input | 2 | Segment chosen by the override |
| offset | input | 16 | Offset for stack and data accesses |
| phys_addr | output | 20 | Physical address |

## Verification
The hardest case to reach is the instruction pointer wrapping at the end of its segment. It must wrap without touching the code base, and this can only be seen through the fetch address. The stimulus loads the pointer with 0xFFFF, checks the fetch address, strobes one fetch, and then reads both the fetch address and the code base, the latter through a data override with a zero offset. The second case is a load and a fetch strobe in the same cycle, and the result must show that the load value is taken without an added step. The segment register contents are checked the same way, through data overrides, after single writes.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int SEG_W_DEF = 16;
    localparam int OFS_W_DEF = 16;
    localparam int SHIFT_DEF = 4;
    localparam int NSEG      = 4;
    localparam int SEL_W     = $clog2(NSEG);

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_STACK = 2'd1,
        ACC_DATA  = 2'd2,
        ACC_DATA2 = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int W = SEG_W_DEF,
    parameter int N = NSEG,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] rsel,
    output logic [W-1:0]  rdata
);
    typedef struct packed {
        logic [N-1:0][W-1:0] seg;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we) begin
            rf_d.seg[wsel] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rdata = rf_q.seg[rsel];

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9: the selected entry takes the written value
        a_r9_write: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wsel == IW'(i)) |=> rf_q.seg[i] == $past(wdata));
        // R9: entries that are not selected keep their values
        a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && wsel == IW'(i)) |=> $stable(rf_q.seg[i]));
        // R10: an edge that samples reset leaves the entry cleared
        a_r10_seg_clear: assert property (@(posedge clk)
            !rst_n |=> rf_q.seg[i] == '0);
    end
endmodule

// File: rtl/ip_counter.sv
module ip_counter
    import seg_addr_pkg::*;
#(
    parameter int W = OFS_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] ip
);
    typedef struct packed {
        logic [W-1:0] ip;
    } ipc_t;

    ipc_t ipc_d, ipc_q;

    always_comb begin
        ipc_d = ipc_q;
        if (load) begin
            ipc_d.ip = load_val;
        end else if (step) begin
            ipc_d.ip = ipc_q.ip + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ipc_q <= '0;
        end else begin
            ipc_q <= ipc_d;
        end
    end

    assign ip = ipc_q.ip;

    // R6: one step per sampled strobe
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ipc_q.ip != '1) |=> ipc_q.ip == $past(ipc_q.ip) + W'(1));
    // R7: the top value wraps to zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ipc_q.ip == '1) |=> ipc_q.ip == '0);
    // R8: a load wins over a step
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ipc_q.ip == $past(load_val));
    // no strobe and no load means the pointer holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(ipc_q.ip));
    // R10: an edge that samples reset leaves the pointer cleared
    a_r10_ip_clear: assert property (@(posedge clk)
        !rst_n |=> ipc_q.ip == '0);
endmodule

// File: rtl/base_select.sv
module base_select
    import seg_addr_pkg::*;
(
    input  logic [1:0]       acc_kind,
    input  logic             ovr_en,
    input  logic [SEL_W-1:0] ovr_seg,
    output logic [SEL_W-1:0] seg_id,
    output logic             use_ip
);
    always_comb begin
        seg_id = SEG_DATA;
        use_ip = 1'b0;
        unique case (acc_kind_e'(acc_kind))
            ACC_FETCH: begin
                seg_id = SEG_CODE;
                use_ip = 1'b1;
            end
            ACC_STACK: seg_id = SEG_STACK;
            ACC_DATA, ACC_DATA2: seg_id = ovr_en ? ovr_seg : SEG_DATA;
            default: seg_id = SEG_DATA;
        endcase
    end
endmodule

// File: rtl/addr_adder.sv
module addr_adder
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF,
    parameter int OFS_W = OFS_W_DEF,
    parameter int SHIFT = SHIFT_DEF,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] base,
    input  logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] base_sh;
    logic [PA_W-1:0] ofs_ext;

    always_comb begin
        base_sh = {base, {SHIFT{1'b0}}};
        ofs_ext = PA_W'(ofs);
        phys    = base_sh + ofs_ext;
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF,
    parameter int OFS_W = OFS_W_DEF,
    parameter int SHIFT = SHIFT_DEF,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_we,
    input  logic [1:0]       seg_sel,
    input  logic [SEG_W-1:0] seg_wdata,
    input  logic             ip_we,
    input  logic [OFS_W-1:0] ip_wdata,
    input  logic             fetch_stb,
    input  logic [1:0]       acc_kind,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_seg,
    input  logic [OFS_W-1:0] offset,
    output logic [PA_W-1:0]  phys_addr
);
    logic [SEL_W-1:0] seg_id;
    logic             use_ip;
    logic [SEG_W-1:0] base;
    logic [OFS_W-1:0] ip;
    logic [OFS_W-1:0] eff_ofs;

    base_select u_sel (
        .acc_kind (acc_kind),
        .ovr_en   (ovr_en),
        .ovr_seg  (ovr_seg),
        .seg_id   (seg_id),
        .use_ip   (use_ip)
    );

    seg_regfile #(.W(SEG_W), .N(NSEG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .wsel  (seg_sel),
        .wdata (seg_wdata),
        .rsel  (seg_id),
        .rdata (base)
    );

    ip_counter #(.W(OFS_W)) u_ip (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ip_we),
        .load_val (ip_wdata),
        .step     (fetch_stb),
        .ip       (ip)
    );

    assign eff_ofs = use_ip ? ip : offset;

    addr_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_add (
        .base (base),
        .ofs  (eff_ofs),
        .phys (phys_addr)
    );

    // R2: a fetch reads the code base with the pointer
    a_r2_fetch_base: assert property (@(posedge clk) disable iff (!rst_n)
        acc_kind == ACC_FETCH |-> (seg_id == SEG_CODE && eff_ofs == ip));
    // R3: a stack access reads the stack base
    a_r3_stack_base: assert property (@(posedge clk) disable iff (!rst_n)
        acc_kind == ACC_STACK |-> (seg_id == SEG_STACK && eff_ofs == offset));
    // R4: a data access without override reads the data base
    a_r4_data_base: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind[1] && !ovr_en) |-> seg_id == SEG_DATA);
    // R5: the override names the base for data accesses
    a_r5_override: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind[1] && ovr_en) |-> (seg_id == ovr_seg && eff_ofs == offset));
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_sel = '0;
    logic [15:0] seg_wdata = '0;
    logic        ip_we = 1'b0;
    logic [15:0] ip_wdata = '0;
    logic        fetch_stb = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [15:0] offset = '0;
    logic [19:0] phys_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seg_addr_gen u0 (.*);

    // {kind[40:39], ovr_en[38], ovr_seg[37:36], offset[35:20], expected[19:0]}
    // Bases: code 0x1234, data 0x2000, stack 0xF000, extra 0xFFFF; pointer 0x0100
    localparam int NV = 9;
    localparam logic [40:0] VEC [NV] = '{
        {2'd2, 1'b0, 2'd0, 16'h0010, 20'h20010},
        {2'd3, 1'b0, 2'd0, 16'h1234, 20'h21234},
        {2'd1, 1'b0, 2'd0, 16'hFFFE, 20'hFFFFE},
        {2'd1, 1'b1, 2'd3, 16'h0001, 20'hF0001},
        {2'd2, 1'b1, 2'd3, 16'h0020, 20'h00010},
        {2'd2, 1'b1, 2'd0, 16'h0005, 20'h12345},
        {2'd0, 1'b0, 2'd0, 16'h7777, 20'h12440},
        {2'd0, 1'b1, 2'd2, 16'h0000, 20'h12440},
        {2'd2, 1'b1, 2'd2, 16'hFFFF, 20'hFFFFF}
    };
    string vtag [NV] = '{"R4", "R4", "R3", "R5", "R1", "R5", "R2", "R5", "R1"};

    task automatic check(input string req, input logic [19:0] exp);
        checks++;
        if (phys_addr !== exp) begin
            errors++;
            $display("FAIL %s: phys_addr=%05h expected %05h", req, phys_addr, exp);
        end
    endtask

    task automatic look(input logic [1:0] k, input logic oe, input logic [1:0] os,
                        input logic [15:0] ofs);
        acc_kind = k;
        ovr_en = oe;
        ovr_seg = os;
        offset = ofs;
        #1;
    endtask

    task automatic wseg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_we = 1'b1;
        seg_sel = sel;
        seg_wdata = val;
        @(negedge clk);
        seg_we = 1'b0;
    endtask

    task automatic wip(input logic [15:0] val);
        @(negedge clk);
        ip_we = 1'b1;
        ip_wdata = val;
        @(negedge clk);
        ip_we = 1'b0;
    endtask

    task automatic fetch_n(input int n);
        @(negedge clk);
        fetch_stb = 1'b1;
        repeat (n) @(negedge clk);
        fetch_stb = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        check("R10 pointer/code", 20'h00000);
        for (int s = 1; s < 4; s++) begin
            look(2'd2, 1'b1, 2'(s), 16'h0000);
            check("R10 segment", 20'h00000);
        end
        rst_n = 1'b1;

        wseg(2'd0, 16'h1234);
        wseg(2'd1, 16'h2000);
        wseg(2'd2, 16'hF000);
        wseg(2'd3, 16'hFFFF);
        wip(16'h0100);

        for (int i = 0; i < NV; i++) begin
            look(VEC[i][40:39], VEC[i][38], VEC[i][37:36], VEC[i][35:20]);
            check(vtag[i], VEC[i][19:0]);
        end

        // R9: a single write leaves the other registers alone
        wseg(2'd1, 16'h3000);
        look(2'd2, 1'b0, 2'd0, 16'h0000);
        check("R9 data written", 20'h30000);
        look(2'd2, 1'b1, 2'd3, 16'h0000);
        check("R9 extra kept", 20'hFFFF0);
        look(2'd1, 1'b0, 2'd0, 16'h0000);
        check("R9 stack kept", 20'hF0000);

        // R6: one step per strobe
        wip(16'h0010);
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        check("R6 start", 20'h12350);
        fetch_n(1);
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        check("R6 one step", 20'h12351);
        fetch_n(3);
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        check("R6 three steps", 20'h12354);

        // R7: wrap at the segment end, code base unchanged
        wip(16'hFFFF);
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        check("R7 at top", 20'h2233F);
        fetch_n(1);
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        check("R7 wrapped", 20'h12340);
        look(2'd2, 1'b1, 2'd0, 16'h0000);
        check("R7 code kept", 20'h12340);

        // R8: a load beats a strobe in the same cycle
        @(negedge clk);
        ip_we = 1'b1;
        ip_wdata = 16'h0200;
        fetch_stb = 1'b1;
        @(negedge clk);
        ip_we = 1'b0;
        fetch_stb = 1'b0;
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        check("R8 load wins", 20'h12540);

        // R10: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        check("R10 pointer after reset", 20'h00000);
        look(2'd1, 1'b0, 2'd0, 16'h0040);
        check("R10 stack after reset", 20'h00040);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule